// File: doc/BRIEF.md
# Modified Immediate Constant Expander

This block turns the 12-bit packed immediate carried inside a 32-bit instruction word into the full 32-bit operand constant, together with the shifter carry-out. There is no clock or state. A single mode pin picks one of two packings. In the wide packing, a byte is rotated right by an even amount. In the compact packing, the 12-bit field is gathered from three separate places in the word. That field then either repeats a byte across the word in one of four layouts, or rotates an 8-bit value whose top bit is an implied one.

Beside the main constant, the block gives three other values: the compact 12-bit field zero-extended, two word-scaled offsets taken from the low seven and the low eight bits of the word, and a flag that marks register numbers the compact packing forbids. A decode stage uses these outputs directly and picks whichever ones the current instruction needs. The block decodes nothing else in the instruction.

Top module: `imm_expand_top`

## Requirements
- R1: With `enc_mode` = 0 (wide packing), `const_value` equals `instr_word[7:0]` zero-extended and then rotated right by 2 × `instr_word[11:8]`.
- R2: With `enc_mode` = 0, `carry_out` equals `carry_in` when `instr_word[11:8]` is zero, and equals `const_value[31]` otherwise.
- R3: The compact field is {`instr_word[26]`, `instr_word[14:12]`, `instr_word[7:0]`}, with bit 26 as the most significant bit. No other bit of `instr_word` affects the compact constant.
- R4: With `enc_mode` = 1 and compact field bits 11:10 equal to 00, let B be field bits 7:0. Field bits 9:8 then select the constant: 0 gives 000000BB, 1 gives 00BB00BB, 2 gives BB00BB00, and 3 gives BBBBBBBB. In this case `carry_out` equals `carry_in`.
- R5: With `enc_mode` = 1 and compact field bits 11:10 nonzero, `const_value` is the 8-bit value {1, field[6:0]} zero-extended and rotated right by field[11:7]. In this case `carry_out` equals `const_value[31]`.
- R6: `imm12_zext` equals the compact field zero-extended to 32 bits, in both modes.
- R7: `off7_x4` equals `instr_word[6:0]` × 4, zero-extended.
- R8: `off8_x4` equals `instr_word[7:0]` × 4, zero-extended.
- R9: `reg_forbidden` is 1 exactly when `reg_num` is 13 or 15.
- R10: All outputs are combinational. After any input change they settle to the values above before the next sample, and they keep no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word carrying the packed immediate |
| enc_mode | input | 1 | 0 = wide packing, 1 = compact packing |
| carry_in | input | 1 | Incoming shifter carry |
| reg_num | input | 4 | Register number to screen |
| const_value | output | 32 | Expanded 32-bit constant |
| carry_out | output | 1 | Carry produced by the expansion |
| imm12_zext | output | 32 | Compact 12-bit field, zero-extended |
| off7_x4 | output | 32 | Low 7 bits scaled by 4 |
| off8_x4 | output | 32 | Low 8 bits scaled by 4 |
| reg_forbidden | output | 1 | Register number is 13 or 15 |

## Verification
The assertions assume that every input is a known 0 or 1 whenever they are evaluated. They also assume that `enc_mode` is one of its two defined codes, so every field combination is legal. The stimulus drives all inputs from the first instant with defined values. It sweeps every 12-bit field value in both modes with both carry values, and fills the bits outside the field with seeded random data. Those random filler bits also show that bits outside the field have no effect on the constant.

// File: rtl/imm_exp_pkg.sv
// Package: shared widths, mode encoding and result type for the
// immediate expander. Assumes a 32-bit word built from four byte lanes.
package imm_exp_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 12;
    localparam int ROT_W   = 5;
    localparam int REG_W   = 4;
    localparam int LANES   = WORD_W / BYTE_W;

    typedef enum logic {
        ENC_WIDE    = 1'b0,
        ENC_COMPACT = 1'b1
    } enc_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
    } exp_result_t;
endpackage

// File: rtl/rotr_barrel.sv
// Module: rotr_barrel
// Log-depth rotate-right network. One stage per bit of the amount; stage k
// rotates by 2**k when amount bit k is set. Assumes 2**(SH_W-1) < W.
module rotr_barrel #(
    parameter int W    = 32,
    parameter int SH_W = 5
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [W-1:0] stg [0:SH_W];

    // Stage 0 is the raw input.
    assign stg[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        // Conditionally rotate by this stage's power of two.
        assign stg[k+1] = amt[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
    end

    assign dout = stg[SH_W];

    // Guard: a rotation never changes the number of set bits (R1, R5).
    always_comb begin
        p_rot_popcount_r1: assert ($countones(dout) == $countones(din))
            else $error("rotator changed population count");
    end
endmodule

// File: rtl/wide_expand.sv
// Module: wide_expand
// Wide packing: byte in field[7:0] rotated right by twice field[11:8].
// Carry passes through for a zero rotation, else takes result bit WORD_W-1.
module wide_expand
    import imm_exp_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int W  = WORD_W
) (
    input  logic [FW-1:0] field,
    input  logic          carry_in,
    output exp_result_t   res
);
    localparam int BW  = BYTE_W;
    localparam int RW  = FW - BW;   // width of the rotate nibble
    localparam int SHW = RW + 1;    // doubled amount width

    logic [W-1:0]   rot_out;
    logic [SHW-1:0] amount;
    logic           rot_zero;

    // Doubled rotate amount and its zero test.
    always_comb begin
        amount   = {field[FW-1:BW], 1'b0};
        rot_zero = (field[FW-1:BW] == '0);
    end

    rotr_barrel #(.W(W), .SH_W(SHW)) u_rot (
        .din  ({{(W-BW){1'b0}}, field[BW-1:0]}),
        .amt  (amount),
        .dout (rot_out)
    );

    // Result and carry selection.
    always_comb begin
        res.value = rot_out;
        res.carry = rot_zero ? carry_in : rot_out[W-1];
    end

    // Guard: zero rotation leaves the byte in place, upper bits clear (R1).
    always_comb begin
        if (rot_zero) begin
            p_wide_norot_r1: assert (res.value[W-1:BW] == '0 &&
                                     res.value[BW-1:0] == field[BW-1:0])
                else $error("wide path moved byte without rotation");
        end
    end
endmodule

// File: rtl/compact_expand.sv
// Module: compact_expand
// Compact packing: top two field bits zero selects byte replication by
// field[9:8]; otherwise {1,field[6:0]} is rotated right by field[11:7].
module compact_expand
    import imm_exp_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int W  = WORD_W
) (
    input  logic [FW-1:0] field,
    input  logic          carry_in,
    output exp_result_t   res
);
    localparam int BW = BYTE_W;
    localparam int NL = W / BW;
    localparam int SW = ROT_W;

    logic [NL-1:0] lane_en;
    logic [W-1:0]  rep_val;
    logic [W-1:0]  rot_val;
    logic          rep_sel;

    // Which byte lanes carry the byte for each replication pattern.
    always_comb begin
        rep_sel = (field[FW-1:FW-2] == 2'b00);
        lane_en = '0;
        for (int i = 0; i < NL; i++) begin
            case (field[FW-3:FW-4])
                2'd0:    lane_en[i] = (i == 0);
                2'd1:    lane_en[i] = (i % 2 == 0);
                2'd2:    lane_en[i] = (i % 2 == 1);
                default: lane_en[i] = 1'b1;
            endcase
        end
    end

    for (genvar b = 0; b < NL; b++) begin : g_lane
        // Fill one lane with the byte or zero.
        assign rep_val[b*BW +: BW] = lane_en[b] ? field[BW-1:0] : '0;
    end

    rotr_barrel #(.W(W), .SH_W(SW)) u_rot (
        .din  ({{(W-BW){1'b0}}, 1'b1, field[BW-2:0]}),
        .amt  (field[FW-1:FW-SW]),
        .dout (rot_val)
    );

    // Pick the path and its carry rule.
    always_comb begin
        res.value = rep_sel ? rep_val : rot_val;
        res.carry = rep_sel ? carry_in : rot_val[W-1];
    end

    // Guards for both paths (R4, R5).
    always_comb begin
        if (rep_sel) begin
            p_rep_carry_r4: assert (res.carry == carry_in)
                else $error("replication path altered carry");
            if (field[FW-3:FW-4] == 2'd3) begin
                p_rep_all_r4: assert (res.value[W-1:W-BW] == res.value[BW-1:0])
                    else $error("full replication mismatch");
            end
        end else begin
            p_rot_ones_r5: assert ($countones(res.value) ==
                                   1 + $countones(field[BW-2:0]))
                else $error("implied one bit lost");
        end
    end
endmodule

// File: rtl/aux_fields.sv
// Module: aux_fields
// Side outputs: zero-extended compact field, two word-scaled offsets and
// the forbidden-register flag. Assumes field already gathered upstream.
module aux_fields
    import imm_exp_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int FW = FIELD_W,
    parameter int RW = REG_W
) (
    input  logic [W-1:0]  word,
    input  logic [FW-1:0] field,
    input  logic [RW-1:0] reg_num,
    output logic [W-1:0]  imm12_zext,
    output logic [W-1:0]  off7_x4,
    output logic [W-1:0]  off8_x4,
    output logic          reg_forbidden
);
    localparam int B7 = 7;
    localparam int B8 = 8;
    localparam logic [RW-1:0] BAD_A = RW'(13);
    localparam logic [RW-1:0] BAD_B = RW'(15);

    // Extension, scaling and register screen.
    always_comb begin
        imm12_zext    = {{(W-FW){1'b0}}, field};
        off7_x4       = {{(W-B7-2){1'b0}}, word[B7-1:0], 2'b00};
        off8_x4       = {{(W-B8-2){1'b0}}, word[B8-1:0], 2'b00};
        reg_forbidden = (reg_num == BAD_A) || (reg_num == BAD_B);
    end

    // Guards on scaled ranges and the flag (R7, R8, R9).
    always_comb begin
        p_off7_range_r7: assert (off7_x4 <= W'(508) && off7_x4[1:0] == 2'b00)
            else $error("off7 out of range");
        p_off8_range_r8: assert (off8_x4 <= W'(1020) && off8_x4[1:0] == 2'b00)
            else $error("off8 out of range");
        if (reg_forbidden) begin
            p_badreg_bits_r9: assert (reg_num[0] && reg_num[2] && reg_num[3])
                else $error("flag on a permitted register");
        end
    end
endmodule

// File: rtl/imm_expand_top.sv
// Module: imm_expand_top
// Combinational immediate expander. Gathers the compact field, runs both
// packings in parallel and selects by enc_mode. No clock, no state.
module imm_expand_top
    import imm_exp_pkg::*;
(
    input  logic [31:0] instr_word,
    input  logic        enc_mode,
    input  logic        carry_in,
    input  logic [3:0]  reg_num,
    output logic [31:0] const_value,
    output logic        carry_out,
    output logic [31:0] imm12_zext,
    output logic [31:0] off7_x4,
    output logic [31:0] off8_x4,
    output logic        reg_forbidden
);
    localparam int HI_BIT = 26;
    localparam int MID_HI = 14;
    localparam int MID_LO = 12;

    logic [FIELD_W-1:0] cfield;
    exp_result_t        wide_res;
    exp_result_t        cmp_res;
    enc_mode_e          mode;

    // Gather the compact field from its three places.
    always_comb begin
        cfield = {instr_word[HI_BIT], instr_word[MID_HI:MID_LO],
                  instr_word[BYTE_W-1:0]};
        mode   = enc_mode_e'(enc_mode);
    end

    wide_expand #(.FW(FIELD_W), .W(WORD_W)) u_wide (
        .field    (instr_word[FIELD_W-1:0]),
        .carry_in (carry_in),
        .res      (wide_res)
    );

    compact_expand #(.FW(FIELD_W), .W(WORD_W)) u_cmp (
        .field    (cfield),
        .carry_in (carry_in),
        .res      (cmp_res)
    );

    aux_fields #(.W(WORD_W), .FW(FIELD_W), .RW(REG_W)) u_aux (
        .word          (instr_word),
        .field         (cfield),
        .reg_num       (reg_num),
        .imm12_zext    (imm12_zext),
        .off7_x4       (off7_x4),
        .off8_x4       (off8_x4),
        .reg_forbidden (reg_forbidden)
    );

    // Mode select of constant and carry.
    always_comb begin
        if (mode == ENC_COMPACT) begin
            const_value = cmp_res.value;
            carry_out   = cmp_res.carry;
        end else begin
            const_value = wide_res.value;
            carry_out   = wide_res.carry;
        end
    end

    // Guards at the output mux (R2, R4).
    always_comb begin
        if (mode == ENC_WIDE && instr_word[11:8] == 4'd0) begin
            p_wide_carry_r2: assert (carry_out == carry_in)
                else $error("wide zero-rotate carry not passed");
        end
        if (mode == ENC_COMPACT && imm12_zext[11:10] == 2'b00) begin
            p_top_repcarry_r4: assert (carry_out == carry_in)
                else $error("replication carry not passed");
        end
    end
endmodule

// File: tb/tb_imm_expand_top.sv
// Bench: full field sweep in both modes and both carries, random filler
// bits from a fixed seed, plus directed corners.
module tb_imm_expand_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_word = '0;
    logic        enc_mode = 1'b0;
    logic        carry_in = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [31:0] const_value, imm12_zext, off7_x4, off8_x4;
    logic        carry_out, reg_forbidden;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    imm_expand_top dut (
        .instr_word    (instr_word),
        .enc_mode      (enc_mode),
        .carry_in      (carry_in),
        .reg_num       (reg_num),
        .const_value   (const_value),
        .carry_out     (carry_out),
        .imm12_zext    (imm12_zext),
        .off7_x4       (off7_x4),
        .off8_x4       (off8_x4),
        .reg_forbidden (reg_forbidden)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: counts cycles, fails the run if it hangs.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic logic [31:0] ref_ror(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
        return r;
    endfunction

    function automatic logic [11:0] ref_field(input logic [31:0] w);
        return {w[26], w[14:12], w[7:0]};
    endfunction

    function automatic logic [32:0] ref_const(input logic [31:0] w, input logic m,
                                              input logic c);
        logic [11:0] f;
        logic [31:0] v;
        logic [7:0]  b;
        logic        co;
        if (!m) begin
            v  = ref_ror({24'd0, w[7:0]}, 2 * int'(w[11:8]));
            co = (w[11:8] == 0) ? c : v[31];
        end else begin
            f = ref_field(w);
            b = f[7:0];
            if (f[11:10] == 0) begin
                case (f[9:8])
                    2'd0: v = {24'd0, b};
                    2'd1: v = {8'd0, b, 8'd0, b};
                    2'd2: v = {b, 8'd0, b, 8'd0};
                    default: v = {b, b, b, b};
                endcase
                co = c;
            end else begin
                v  = ref_ror({24'd0, 1'b1, f[6:0]}, int'(f[11:7]));
                co = v[31];
            end
        end
        return {co, v};
    endfunction

    task automatic apply(input logic [31:0] w, input logic m, input logic c,
                         input logic [3:0] r);
        logic [32:0] e;
        bit bad = 0;
        @(posedge clk);
        instr_word = w; enc_mode = m; carry_in = c; reg_num = r;
        @(negedge clk);
        e = ref_const(w, m, c);
        vectors++;
        if (const_value !== e[31:0]) begin
            bad = 1;
            $display("FAIL %s const: got %h expected %h (w=%h)",
                     m ? "R3/R4/R5" : "R1", const_value, e[31:0], w);
        end
        if (carry_out !== e[32]) begin
            bad = 1;
            $display("FAIL %s carry: got %b expected %b (w=%h c=%b)",
                     m ? "R4/R5" : "R2", carry_out, e[32], w, c);
        end
        if (imm12_zext !== {20'd0, ref_field(w)}) begin
            bad = 1;
            $display("FAIL R6 imm12: got %h expected %h", imm12_zext, {20'd0, ref_field(w)});
        end
        if (off7_x4 !== 32'(w[6:0]) * 4) begin
            bad = 1;
            $display("FAIL R7 off7: got %h expected %h", off7_x4, 32'(w[6:0]) * 4);
        end
        if (off8_x4 !== 32'(w[7:0]) * 4) begin
            bad = 1;
            $display("FAIL R8 off8: got %h expected %h", off8_x4, 32'(w[7:0]) * 4);
        end
        if (reg_forbidden !== (r == 13 || r == 15)) begin
            bad = 1;
            $display("FAIL R9 regflag: got %b expected %b (r=%0d)",
                     reg_forbidden, (r == 13 || r == 15), r);
        end
        if (bad) miscompares++;
    endtask

    initial begin
        int seed_dummy;
        logic [31:0] w;
        seed_dummy = $urandom(32'h1d2c3b4a);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R10: idle inputs all zero give zero outputs, carry passed.
        apply(32'd0, 1'b0, 1'b0, 4'd0);
        apply(32'd0, 1'b1, 1'b1, 4'd0);
        // Directed corners R1 R2 R4 R5 R9.
        apply(32'h0000_0FFF, 1'b0, 1'b0, 4'd13);
        apply(32'h0000_01FF, 1'b0, 1'b1, 4'd15);
        apply(32'h0000_00AB, 1'b0, 1'b1, 4'd14);
        apply(32'h0000_33C5, 1'b1, 1'b0, 4'd12);
        apply(32'h0400_7FFF, 1'b1, 1'b0, 4'd11);
        apply(32'h0000_1080, 1'b1, 1'b1, 4'd13);
        // Full sweep: every field value, both modes, both carries (R1..R8).
        for (int f = 0; f < 4096; f++) begin
            for (int m = 0; m < 2; m++) begin
                for (int c = 0; c < 2; c++) begin
                    w = $urandom;
                    if (m == 0) w[11:0] = f[11:0];
                    else begin
                        w[26] = f[11]; w[14:12] = f[10:8]; w[7:0] = f[7:0];
                    end
                    apply(w, m[0], c[0], 4'(f + m + c));
                end
            end
        end
        // R3: random words in both modes; filler bits must not matter.
        for (int i = 0; i < 1000; i++) begin
            apply($urandom, 1'($urandom), 1'($urandom), 4'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule